// File: doc/BRIEF.md
# Digital Retriggerable One-Shot

This block is a clocked monostable pulse generator. It watches a trigger line that is already synchronous to the clock. A rising edge on the trigger drives the output `q_out` from its resting level of 0 to 1. The output stays high for a programmed number of clock cycles and then falls back to 0 without any further stimulus. The complementary output `q_n_out` always shows the opposite level.

A mode input is sampled at each trigger and selects how that trigger is handled. In one-shot mode, edges that arrive while the pulse is high are dropped. In retrigger mode, every edge restarts the full pulse length from that edge, so a steady stream of edges can hold the output high indefinitely.

The pulse length is an unsigned cycle count. It is captured only when a trigger starts or restarts the timing.

Top module: `oneshot_pulse`

## Requirements
- R1: A synchronous reset forces `q_out`=0 and `q_n_out`=1 and clears the trigger history. A trigger that is still high on the first clock after reset is therefore seen as a new rising edge.
- R2: `q_n_out` is the logical inverse of `q_out` in every cycle.
- R3: A trigger edge is detected at a clock edge when `trig_in` is 1 and was 0 at the previous clock edge. An accepted edge raises `q_out` from the cycle that follows that clock edge. Holding `trig_in` high produces no further edges.
- R4: After an accepted start, `q_out` is 1 for exactly `pulse_len` cycles and then returns to 0 on its own.
- R5: A `pulse_len` of 0 behaves as a length of 1.
- R6: With `retrig_en`=0, an edge that arrives while `q_out` is 1 has no effect. This includes an edge in the last high cycle of a pulse: the pulse ends on time, and the following cycle is 0.
- R7: With `retrig_en`=1, an edge that arrives while `q_out` is 1 restarts a full `pulse_len` interval, counted from that edge. An edge in the last high cycle extends the pulse with no low gap.
- R8: A change to `pulse_len` during a pulse does not move the end of that pulse. The new value applies from the next accepted start or restart.
- R9: A change to `retrig_en` during a pulse has no effect on its own. It governs only trigger edges that arrive after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Trigger line; its rising edges are the events |
| retrig_en | input | 1 | 1 = retrigger mode, 0 = one-shot mode |
| pulse_len | input | CNT_W (16) | Pulse length in clock cycles; 0 acts as 1 |
| q_out | output | 1 | Pulse output, rests at 0 |
| q_n_out | output | 1 | Inverse of `q_out` |

## Verification
The properties assume that `trig_in`, `retrig_en` and `pulse_len` change only between clock edges. They also assume that reset is held at the first clock edge, so that the trigger history kept in the checker starts out aligned with the block's own history. The bench meets these assumptions by changing every input on the falling clock edge. It opens the run with reset asserted and applies reset again later with the trigger held high. Random trigger patterns change the mode and the length in the middle of pulses. They use short lengths, so that edges land often on the final high cycle and in the gap just after a pulse.

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] pulse_len,
  output logic             q_out,
  output logic             q_n_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             trig_q;
  logic [CNT_W-1:0] remain;
  logic             edge_seen;
  logic             accept;
  logic [CNT_W-1:0] load_val;

  assign edge_seen = trig_in & ~trig_q;
  assign accept    = edge_seen & (~q_out | retrig_en);
  assign load_val  = (pulse_len == '0) ? ONE : pulse_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      remain <= '0;
    end else begin
      trig_q <= trig_in;
      if (accept)
        remain <= load_val;
      else if (remain != '0)
        remain <= remain - ONE;
    end
  end

  assign q_out   = (remain != '0);
  assign q_n_out = ~q_out;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_in,
  input logic             retrig_en,
  input logic [CNT_W-1:0] pulse_len,
  input logic             q_out,
  input logic             q_n_out
);

  logic rst_q = 1'b1;
  logic trg_q = 1'b0;
  logic edg;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    trg_q <= rst ? 1'b0 : trig_in;
  end

  assign edg = trig_in & ~trg_q;

  p_reset_rest_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!q_out && q_n_out));

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (edg && !q_out) |=> q_out);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && $rose(q_out)) |-> $past(edg));

  p_min_len_r5: assert property (@(posedge clk) disable iff (rst)
    (edg && !q_out && pulse_len <= CNT_W'(1)) |=> q_out ##1 !q_out);

  p_retrig_r7: assert property (@(posedge clk) disable iff (rst)
    (edg && retrig_en) |=> q_out);

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_oneshot_pulse.sv
module tb_oneshot_pulse;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0;
  logic retrig_en = 1'b0;
  logic [CNT_W-1:0] pulse_len = '0;
  logic q_out, q_n_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int end_cyc = 0;
  bit prev_trig = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  oneshot_pulse #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .retrig_en(retrig_en),
    .pulse_len(pulse_len), .q_out(q_out), .q_n_out(q_n_out));

  function automatic int eff_len(input logic [CNT_W-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  function automatic bit expect_high(input int c, input int e);
    return c < e;
  endfunction

  task automatic step(input bit t, input bit m, input int l, input bit r);
    bit edg;
    bit acc;
    @(negedge clk);
    trig_in = t; retrig_en = m; pulse_len = CNT_W'(l); rst = r;
    @(posedge clk);
    cyc++;
    if (r) begin
      prev_trig = 1'b0;
      end_cyc = cyc;
    end else begin
      edg = t && !prev_trig;
      acc = edg && (m || !expect_high(cyc - 1, end_cyc));
      if (acc) end_cyc = cyc + eff_len(CNT_W'(l));
      prev_trig = t;
    end
    #1;
    checks++;
    if (q_out !== expect_high(cyc, end_cyc)) begin
      errors++;
      $display("FAIL %s cycle %0d q_out actual %b expected %b", tag, cyc, q_out,
               expect_high(cyc, end_cyc));
    end
    checks++;
    if (q_n_out !== ~q_out) begin
      errors++;
      $display("FAIL R2 cycle %0d q_n_out actual %b expected %b", cyc, q_n_out, ~q_out);
    end
  endtask

  task automatic run(input bit t, input bit m, input int l, input int n);
    for (int i = 0; i < n; i++) step(t, m, l, 1'b0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4, 1'b1);
    run(1'b1, 1'b0, 4, 6);
    run(1'b0, 1'b0, 4, 3);

    tag = "R3";
    run(1'b1, 1'b0, 3, 20);
    run(1'b0, 1'b0, 3, 4);

    tag = "R4";
    run(1'b1, 1'b0, 5, 1);
    run(1'b0, 1'b0, 5, 8);
    run(1'b1, 1'b1, 9, 12);
    run(1'b0, 1'b1, 9, 2);

    tag = "R5";
    run(1'b1, 1'b0, 0, 1);
    run(1'b0, 1'b0, 0, 3);
    run(1'b1, 1'b1, 0, 1);
    run(1'b0, 1'b1, 0, 3);

    tag = "R6";
    run(1'b1, 1'b0, 4, 1);
    run(1'b0, 1'b0, 4, 2);
    run(1'b1, 1'b0, 4, 1);
    run(1'b0, 1'b0, 4, 4);
    run(1'b1, 1'b0, 6, 1);
    run(1'b0, 1'b0, 6, 1);
    run(1'b1, 1'b0, 6, 1);
    run(1'b0, 1'b0, 6, 8);

    tag = "R7";
    run(1'b1, 1'b1, 4, 1);
    run(1'b0, 1'b1, 4, 2);
    run(1'b1, 1'b1, 4, 1);
    run(1'b0, 1'b1, 4, 1);
    run(1'b1, 1'b1, 4, 1);
    run(1'b0, 1'b1, 4, 7);

    tag = "R8";
    run(1'b1, 1'b0, 8, 1);
    run(1'b0, 1'b0, 2, 3);
    run(1'b0, 1'b0, 20, 7);
    run(1'b1, 1'b0, 2, 1);
    run(1'b0, 1'b0, 9, 4);

    tag = "R9";
    run(1'b1, 1'b1, 5, 1);
    run(1'b0, 1'b0, 5, 1);
    run(1'b1, 1'b0, 5, 1);
    run(1'b0, 1'b1, 5, 1);
    run(1'b1, 1'b1, 5, 1);
    run(1'b0, 1'b0, 5, 8);

    tag = "R1";
    step(1'b1, 1'b0, 3, 1'b1);
    run(1'b1, 1'b0, 3, 5);

    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      bit t;
      bit m;
      int l;
      t = ($urandom % 3) != 0;
      m = ($urandom % 2) != 0;
      l = int'($urandom % 7);
      step(t, m, l, ($urandom % 500) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule